// File: doc/BRIEF.md
# Receive Sample-Delay Tuning Search Engine

This block is a hardware sequencer that finds a good receive sample-delay setting for a high-speed card interface. When started in one of the tunable speed modes, it steps a 6-bit delay tap upward from zero, commits each new tap to the delay line through an update-request handshake, and then asks an external tester whether a tuning transfer passes at that tap. The tester returns one pass/fail result per request.

While sweeping, the engine keeps two run lengths: the current run of consecutive passing taps and the longest run seen so far, together with the tap where that longest run ended. When the sweep is over, it applies the centre of the longest run and raises a done pulse. If no tap passed, it raises an error with the done pulse and leaves the delay line alone. In the slower modes, a start request finishes at once and changes nothing.

The tap update handshake is issued twice for every new value. This guards against a timing weakness in the receive path, and the engine waits for the second self-clear before it tests the tap.

Top module: `tune_sweep_engine`

## Requirements
- R1: After reset, tap_o is 0 and upd_o, test_req_o, busy_o, done_o and err_o are all 0.
- R2: A tuning run requests exactly 40 tests. The tap_o values at those requests are 0, 1, ..., 39 in that order, and tap_o never exceeds 39.
- R3: Every new tap is committed by exactly two update requests. upd_o stays high until upd_ack_i is seen, tap_o does not change while upd_o is high, and the test request for a tap starts only after the second acknowledge.
- R4: test_req_o stays high until test_rsp_valid_i is returned, and test_req_o and upd_o are never high together. The engine does not advance without a response.
- R5: The chosen tap is E - L/2, with truncating division, where L is the length of the longest run of consecutive passing taps and E is the last tap of that run. When several runs share the longest length, the earliest one is chosen.
- R6: If no tap passes, done_o and err_o pulse together for one cycle, no further update requests are made after the last test, and tap_o keeps 39. err_o is never high without done_o.
- R7: If at least one tap passes, the chosen tap is driven on tap_o and committed with two update requests before done_o pulses with err_o low.
- R8: Tuning runs only for mode_i codes 4 and 5. For any other code, start_i gives a done_o pulse on the next cycle with err_o low, busy_o never rises, no requests are made and tap_o is unchanged.
- R9: start_i while busy_o is high has no effect on the run in progress or its result. busy_o is high from the accepted start until the cycle of done_o, and is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for a tuning request |
| mode_i | input | 3 | Current bus speed mode; codes 4 and 5 are tunable |
| tap_o | output | 6 | Receive sample-delay tap driven to the delay line |
| upd_o | output | 1 | Update request; held until acknowledged |
| upd_ack_i | input | 1 | Delay line reports the update complete (the bit self-clears) |
| test_req_o | output | 1 | Request for a tuning transfer at the current tap |
| test_rsp_valid_i | input | 1 | Tester result is valid this cycle |
| test_rsp_pass_i | input | 1 | Tester result: 1 pass, 0 fail |
| busy_o | output | 1 | A tuning run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a request |
| err_o | output | 1 | With done_o: no passing tap was found |

## Verification
A corrupted current-run or best-run counter shows up only at the end of the sweep, as a wrong tap_o in the done cycle. For that reason the pass patterns are chosen so that each one produces a different centre: ties, even and odd run lengths, a run at each end of the range, and no pass at all. A fault in the commit sequencer shows up within a single tap step, as a missing or extra update request before the next test request. A fault in the sweep counter shows up at the first test request, where tap_o no longer matches the request's position in the sweep.

// File: rtl/tune_pkg.sv
package tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMMIT,
    ST_TEST,
    ST_DECIDE,
    ST_FINAL
  } tune_state_e;

  localparam logic [2:0] MODE_FAST_A = 3'd4;
  localparam logic [2:0] MODE_FAST_B = 3'd5;

  function automatic logic mode_is_tunable(input logic [2:0] m);
    return (m == MODE_FAST_A) || (m == MODE_FAST_B);
  endfunction
endpackage

// File: rtl/tap_commit.sv
module tap_commit #(
  parameter int REPEAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic ack_i,
  output logic upd_o,
  output logic done_o
);
  localparam int RW = (REPEAT > 1) ? $clog2(REPEAT) : 1;
  localparam logic [RW-1:0] LAST = RW'(REPEAT - 1);

  logic          active_q;
  logic          upd_q;
  logic          done_q;
  logic [RW-1:0] cnt_q;

  logic ack_seen;
  assign ack_seen = active_q && upd_q && ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      upd_q    <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        upd_q    <= 1'b1;
        cnt_q    <= '0;
      end else if (ack_seen) begin
        upd_q <= 1'b0;
        if (cnt_q == LAST) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (active_q && !upd_q) begin
        upd_q <= 1'b1;
      end
    end
  end

  assign upd_o  = upd_q;
  assign done_o = done_q;
endmodule

// File: rtl/streak_tracker.sv
module streak_tracker #(
  parameter int TAP_W = 6,
  parameter int SWEEP_LEN = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] idx_i,
  output logic             any_pass_o,
  output logic [TAP_W-1:0] center_o
);
  localparam int LW = $clog2(SWEEP_LEN + 1);

  logic [LW-1:0]    cur_q, best_q;
  logic [TAP_W-1:0] end_q;
  logic [LW-1:0]    cur_inc;
  logic             longer;

  function automatic logic [TAP_W-1:0] run_center(input logic [TAP_W-1:0] last_idx,
                                                  input logic [LW-1:0] len);
    logic [LW-1:0] half;
    half = len >> 1;
    return last_idx - TAP_W'(half);
  endfunction

  assign cur_inc = cur_q + 1'b1;
  assign longer  = cur_inc > best_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (step_i) begin
      if (pass_i) begin
        cur_q <= cur_inc;
        if (longer) begin
          best_q <= cur_inc;
          end_q  <= idx_i;
        end
      end else begin
        cur_q <= '0;
      end
    end
  end

  assign any_pass_o = (best_q != '0);
  assign center_o   = run_center(end_q, best_q);
endmodule

// File: rtl/tune_sweep_engine.sv
module tune_sweep_engine
  import tune_pkg::*;
#(
  parameter int TAP_W = 6,
  parameter int SWEEP_LEN = 40,
  parameter int UPD_REPEAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       mode_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             upd_o,
  input  logic             upd_ack_i,
  output logic             test_req_o,
  input  logic             test_rsp_valid_i,
  input  logic             test_rsp_pass_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(SWEEP_LEN - 1);

  tune_state_e      state_q;
  logic [TAP_W-1:0] tap_q;
  logic             done_q, err_q;

  // named internal events
  logic sweep_begin, step_take, last_step, commit_go, commit_done;
  logic any_pass;
  logic [TAP_W-1:0] center_tap;

  assign sweep_begin = (state_q == ST_IDLE) && start_i && mode_is_tunable(mode_i);
  assign step_take   = (state_q == ST_TEST) && test_rsp_valid_i;
  assign last_step   = (tap_q == LAST_TAP);
  assign commit_go   = sweep_begin
                     || (step_take && !last_step)
                     || ((state_q == ST_DECIDE) && any_pass);

  tap_commit #(.REPEAT(UPD_REPEAT)) u_commit (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (commit_go),
    .ack_i  (upd_ack_i),
    .upd_o  (upd_o),
    .done_o (commit_done)
  );

  streak_tracker #(.TAP_W(TAP_W), .SWEEP_LEN(SWEEP_LEN)) u_streak (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (sweep_begin),
    .step_i     (step_take),
    .pass_i     (test_rsp_pass_i),
    .idx_i      (tap_q),
    .any_pass_o (any_pass),
    .center_o   (center_tap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (sweep_begin) begin
            tap_q   <= '0;
            state_q <= ST_COMMIT;
          end else if (start_i) begin
            done_q <= 1'b1;
          end
        end
        ST_COMMIT: begin
          if (commit_done) state_q <= ST_TEST;
        end
        ST_TEST: begin
          if (step_take) begin
            if (last_step) begin
              state_q <= ST_DECIDE;
            end else begin
              tap_q   <= tap_q + 1'b1;
              state_q <= ST_COMMIT;
            end
          end
        end
        ST_DECIDE: begin
          if (any_pass) begin
            tap_q   <= center_tap;
            state_q <= ST_FINAL;
          end else begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_FINAL: begin
          if (commit_done) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tap_o      = tap_q;
  assign test_req_o = (state_q == ST_TEST);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
endmodule

// File: rtl/tune_sweep_chk.sv
module tune_sweep_chk #(
  parameter int TAP_W = 6,
  parameter int SWEEP_LEN = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TAP_W-1:0] tap_o,
  input logic             upd_o,
  input logic             upd_ack_i,
  input logic             test_req_o,
  input logic             test_rsp_valid_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o
);
  // R3
  upd_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && !upd_ack_i) |=> upd_o);

  // R3
  tap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && $past(upd_o)) |-> $stable(tap_o));

  // R4
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req_o && !test_rsp_valid_i) |=> test_req_o);

  // R4
  req_upd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_req_o && upd_o));

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R2
  tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_o <= TAP_W'(SWEEP_LEN - 1));
endmodule

bind tune_sweep_engine tune_sweep_chk #(.TAP_W(TAP_W), .SWEEP_LEN(SWEEP_LEN)) u_chk (.*);

// File: tb/tb_tune_sweep_engine.sv
module tb_tune_sweep_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic [5:0] tap_o;
  logic       upd_o, upd_ack_i = 1'b0;
  logic       test_req_o, test_rsp_valid_i = 1'b0, test_rsp_pass_i = 1'b0;
  logic       busy_o, done_o, err_o;

  int errors = 0;
  int checks = 0;
  logic [39:0] pattern = '0;
  int ack_dly = 0;
  int rsp_dly = 0;

  // behavioural observation counters
  int  req_count, upd_since_tap, upd_after_last_req, tap_moves_in_upd, bad_order;
  bit  prev_upd, prev_req;
  logic [5:0] prev_tap;

  always #2.5 clk = ~clk;

  tune_sweep_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .tap_o(tap_o), .upd_o(upd_o), .upd_ack_i(upd_ack_i),
    .test_req_o(test_req_o), .test_rsp_valid_i(test_rsp_valid_i),
    .test_rsp_pass_i(test_rsp_pass_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // delay line model: acknowledges each update request after ack_dly cycles
  initial begin
    forever begin
      @(negedge clk);
      if (upd_o) begin
        repeat (ack_dly) @(negedge clk);
        upd_ack_i = 1'b1;
        @(negedge clk);
        upd_ack_i = 1'b0;
      end
    end
  end

  // tester model: answers each request from the pass pattern
  initial begin
    forever begin
      @(negedge clk);
      if (test_req_o) begin
        repeat (rsp_dly) @(negedge clk);
        test_rsp_pass_i  = pattern[tap_o];
        test_rsp_valid_i = 1'b1;
        @(negedge clk);
        test_rsp_valid_i = 1'b0;
      end
    end
  end

  // per-clock reference of the handshake ordering
  always @(negedge clk) begin
    if (rst_n) begin
      if (upd_o && prev_upd && tap_o != prev_tap) tap_moves_in_upd++;
      if (upd_o && !prev_upd) begin
        upd_since_tap++;
        upd_after_last_req++;
      end
      if (test_req_o && !prev_req) begin
        if (tap_o != 6'(req_count)) bad_order++;
        if (upd_since_tap != 2) bad_order++;
        req_count++;
        upd_since_tap = 0;
        upd_after_last_req = 0;
      end
      prev_upd = upd_o;
      prev_req = test_req_o;
      prev_tap = tap_o;
    end
  end

  function automatic int expect_tap(input logic [39:0] p, output bit found);
    int best_len = 0;
    int best_end = 0;
    for (int s = 0; s < 40; s++) begin
      bit run_start;
      run_start = p[s] && ((s == 0) ? 1'b1 : !p[s-1]);
      if (run_start) begin
        int e = s;
        while (e < 39 && p[e+1]) e++;
        if (e - s + 1 > best_len) begin
          best_len = e - s + 1;
          best_end = e;
        end
      end
    end
    found = (best_len > 0);
    return found ? best_end - best_len / 2 : 39;
  endfunction

  task automatic clear_obs();
    req_count = 0; upd_since_tap = 0; upd_after_last_req = 0;
    tap_moves_in_upd = 0; bad_order = 0;
  endtask

  task automatic run_tuned(input string tag, input logic [2:0] m, input logic [39:0] p,
                           input int ad, input int rd, input bit extra_start);
    bit found;
    int exp_tap;
    int guard = 0;
    bit saw_busy_at_done = 0;
    exp_tap = expect_tap(p, found);
    pattern = p; ack_dly = ad; rsp_dly = rd;
    clear_obs();
    @(negedge clk);
    mode_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " R9 busy after start"}, busy_o, 1);
    if (extra_start) begin
      repeat (30) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check({tag, " R4 run finished"}, int'(done_o), 1);
    saw_busy_at_done = busy_o;
    check({tag, " R9 busy low at done"}, saw_busy_at_done, 0);
    check({tag, " R2 test count"}, req_count, 40);
    check({tag, " R2 R3 ordering faults"}, bad_order, 0);
    check({tag, " R3 tap moved during update"}, tap_moves_in_upd, 0);
    if (found) begin
      check({tag, " R7 err low"}, err_o, 0);
      check({tag, " R5 chosen tap"}, tap_o, exp_tap);
      check({tag, " R7 final update count"}, upd_after_last_req, 2);
    end else begin
      check({tag, " R6 err high"}, err_o, 1);
      check({tag, " R6 tap kept"}, tap_o, 39);
      check({tag, " R6 no final update"}, upd_after_last_req, 0);
    end
    @(negedge clk);
    check({tag, " R6 done is one cycle"}, done_o, 0);
  endtask

  task automatic run_untuned(input string tag, input logic [2:0] m);
    logic [5:0] tap_before;
    tap_before = tap_o;
    clear_obs();
    @(negedge clk);
    mode_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " R8 done next cycle"}, done_o, 1);
    check({tag, " R8 err low"}, err_o, 0);
    check({tag, " R8 busy stays low"}, busy_o, 0);
    repeat (5) @(negedge clk);
    check({tag, " R8 no requests"}, req_count + upd_after_last_req, 0);
    check({tag, " R8 tap unchanged"}, tap_o, tap_before);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 tap", tap_o, 0);
    check("R1 upd", upd_o, 0);
    check("R1 req", test_req_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 err", err_o, 0);

    run_tuned("all-pass",   3'd4, {40{1'b1}}, 0, 0, 0);
    run_tuned("single-0",   3'd5, 40'h1, 1, 2, 0);
    run_tuned("tie-early",  3'd4, (40'h7 << 2) | (40'h7 << 10), 2, 0, 0);
    run_tuned("even-run",   3'd5, (40'hF << 5) | (40'h1 << 20), 0, 1, 0);
    run_tuned("none-pass",  3'd4, 40'h0, 1, 1, 0);
    run_tuned("top-run",    3'd4, (40'hF << 36) | 40'h3, 3, 3, 1);
    run_untuned("mode2", 3'd2);
    run_untuned("mode0", 3'd0);
    run_tuned("odd-run",    3'd5, (40'h1F << 12) | (40'h3 << 30), 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule